// File: doc/BRIEF.md
# Shadow-Register Timing Slack Sensor

This block wraps one application register and adds an online timing monitor to it. The application (sink) register rebuilds its D input from three sources: the LUT result, a synchronous data word and zero. A synchronous clear, a synchronous load select and a clock enable choose among them, and an asynchronous clear resets the register. A second register, the shadow, is fed by the same rebuilt input and the same controls. It is clocked by a separate shadow clock that runs a small phase behind the application clock. A data change that reaches the register after the application edge but before the shadow edge is therefore held differently by the two registers. That difference is a near-critical arrival.

A third clock domain holds the discrepancy register. It samples the comparison result and keeps it as a sticky error flag until the monitoring controller clears it. A parameter selects the variant. In the gated variant the sink itself is the reference, and a comparison counts only when the sink's last capture came through the watched path: the LUT path, or the synchronous-data path when the polarity parameter is flipped. A one-cycle alignment register on the application clock delays this qualifier so that it matches the compared sample. In the dummy variant a small reference register takes the raw load-select line and replaces the sink as reference. A one-bit shadow copy of the same line is compared against it.

Top module: `slack_sensor`

## Requirements
- R1: While `clrN` is low, `sinkQ` is 0 and `timingErr` is 0 at once, without waiting for a clock.
- R2: On a rising `appClk` edge with `clkEn` high, `sinkQ` takes 0 when `sclr` is 1, whatever `sload` is. It takes `lutOut` when `sclr` and `sload` are both 0.
- R3: On a rising `appClk` edge with `clkEn` high, `sclr` low and `sload` high, `sinkQ` takes `sdata`.
- R4: With `clkEn` low, `sinkQ` holds its value, and a late change of `lutOut` does not set `timingErr`.
- R5: In the gated variant watching the LUT path (`WATCH_SDATA`=0), a `lutOut` change that arrives between an `appClk` edge and the next `shadowClk` edge sets `timingErr` at the next `discClk` edge.
- R6: Inputs that change after the shadow edge and settle before the next application edge never set `timingErr`, in any variant.
- R7: `timingErr` stays 1 after the mismatch is gone. It returns to 0 only on a `discClk` edge that samples `discClear` high, and the clear wins over a new mismatch on that edge.
- R8: In the gated variant with `WATCH_SDATA`=0, a mismatch is ignored when the sink capture at the preceding `appClk` edge was a synchronous load (`sload`=1). A late `sdata` change then leaves `timingErr` at 0.
- R9: In the gated variant with `WATCH_SDATA`=1, only captures with `clkEn`=1, `sclr`=0 and `sload`=1 qualify. A late `sdata` change sets `timingErr`, and a late `lutOut` change does not.
- R10: In the dummy variant (`VARIANT`=VAR_DUMMY), a late change of `sload` sets `timingErr`. Late changes of `lutOut`, `sdata` or `sclr` leave it at 0.
- R11: The shadow register follows the synchronous clear and the load select exactly as the sink does. A late assertion of `sclr`, or a late change of `sload` that alters the selected word, is flagged in the gated variant that watches the LUT path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| appClk | input | 1 | Application clock of the sink register |
| shadowClk | input | 1 | Phase-delayed shadow clock |
| discClk | input | 1 | Clock of the discrepancy register |
| clrN | input | 1 | Asynchronous clear, active low, shared by all registers |
| lutOut | input | WIDTH | Combinational LUT result feeding the register |
| sdata | input | WIDTH | Synchronous load data word |
| sload | input | 1 | Selects `sdata` instead of `lutOut` |
| sclr | input | 1 | Synchronous clear, overrides the load select |
| clkEn | input | 1 | Clock enable for sink and shadow |
| discClear | input | 1 | Synchronous clear of the sticky error flag |
| sinkQ | output | WIDTH | Application register output |
| timingErr | output | 1 | Sticky late-arrival flag |

## Verification
`sinkQ` follows the inputs one `appClk` edge after they settle. A late change becomes a difference two nanoseconds later, at the shadow edge, and `timingErr` shows it at the `discClk` edge five nanoseconds after the application edge. The bench changes safe inputs three nanoseconds after an application edge and late inputs one nanoseconds after it. It samples seven nanoseconds after an application edge, so every check falls after all three clocks have acted and before the next edge. The sticky and clear checks run one and two cycles later, once the sink has caught up. This separates a flag that merely tracks the live mismatch from one that is truly held.

// File: rtl/slack_pkg.sv
package slack_pkg;

  // Which reference the shadow register is compared against.
  typedef enum logic [0:0] {
    VAR_GATED = 1'b0,
    VAR_DUMMY = 1'b1
  } variant_e;

  // Strobes from the control decoder to the datapath input mux and enables.
  typedef struct packed {
    logic pickZero;   // synchronous clear selected
    logic pickSdata;  // synchronous load word selected
    logic advance;    // registers may capture this edge
  } strobes_t;

endpackage

// File: rtl/slack_control.sv
module slack_control
  import slack_pkg::*;
#(
  parameter variant_e VARIANT     = VAR_GATED,
  parameter bit       WATCH_SDATA = 1'b0
) (
  input  logic     appClk,
  input  logic     discClk,
  input  logic     clrN,
  input  logic     sload,
  input  logic     sclr,
  input  logic     clkEn,
  input  logic     discClear,
  input  logic     mismatch,
  output strobes_t strb,
  output logic     errFlag
);

  logic pathBit;
  logic gateNow;
  logic gateQ;
  logic errHit;

  // Decode of the shared register controls; clear outranks load.
  always_comb begin
    strb.pickZero  = sclr;
    strb.pickSdata = sload & ~sclr;
    strb.advance   = clkEn;
  end

  // Which capture path is being watched.
  assign pathBit = WATCH_SDATA ? sload : ~sload;
  assign gateNow = clkEn & ~sclr & pathBit;

  // Alignment stage: the qualifier of the sample the sink just took.
  always_ff @(posedge appClk or negedge clrN) begin
    if (!clrN) gateQ <= 1'b0;
    else       gateQ <= gateNow;
  end

  assign errHit = (VARIANT == VAR_DUMMY) ? mismatch : (mismatch & gateQ);

  // Sticky discrepancy register in its own clock domain.
  always_ff @(posedge discClk or negedge clrN) begin
    if (!clrN)          errFlag <= 1'b0;
    else if (discClear) errFlag <= 1'b0;
    else if (errHit)    errFlag <= 1'b1;
  end

  // R7: the clear has priority on its edge.
  assert_clear_wins_R7: assert property (@(posedge discClk) disable iff (!clrN)
    discClear |=> !errFlag);

  // R7: once set, the flag only falls through a clear.
  assert_flag_sticky_R7: assert property (@(posedge discClk) disable iff (!clrN)
    (errFlag && !discClear) |=> errFlag);

  // R7: a rise never follows an edge that sampled the clear.
  assert_no_rise_after_clear_R7: assert property (@(posedge discClk) disable iff (!clrN)
    $rose(errFlag) |-> !$past(discClear));

endmodule

// File: rtl/slack_datapath.sv
module slack_datapath
  import slack_pkg::*;
#(
  parameter int       WIDTH   = 8,
  parameter variant_e VARIANT = VAR_GATED
) (
  input  logic             appClk,
  input  logic             shadowClk,
  input  logic             clrN,
  input  logic [WIDTH-1:0] lutOut,
  input  logic [WIDTH-1:0] sdata,
  input  logic             sload,
  input  strobes_t         strb,
  output logic [WIDTH-1:0] sinkQ,
  output logic             mismatch
);

  localparam logic [WIDTH-1:0] ZERO_WORD = '0;

  logic [WIDTH-1:0] dRebuilt;

  // Rebuilt D input, shared by the sink and (gated variant) the shadow.
  always_comb begin
    if (strb.pickZero)       dRebuilt = ZERO_WORD;
    else if (strb.pickSdata) dRebuilt = sdata;
    else                     dRebuilt = lutOut;
  end

  // Application (sink) register.
  always_ff @(posedge appClk or negedge clrN) begin
    if (!clrN)             sinkQ <= ZERO_WORD;
    else if (strb.advance) sinkQ <= dRebuilt;
  end

  generate
    if (VARIANT == VAR_GATED) begin : g_gated
      logic [WIDTH-1:0] shadowQ;
      logic             unusedLoad;

      assign unusedLoad = sload;

      always_ff @(posedge shadowClk or negedge clrN) begin
        if (!clrN)             shadowQ <= ZERO_WORD;
        else if (strb.advance) shadowQ <= dRebuilt;
      end

      assign mismatch = (sinkQ != shadowQ);
    end else begin : g_dummy
      logic dummyQ;
      logic shadowBit;

      always_ff @(posedge appClk or negedge clrN) begin
        if (!clrN) dummyQ <= 1'b0;
        else       dummyQ <= sload;
      end

      always_ff @(posedge shadowClk or negedge clrN) begin
        if (!clrN) shadowBit <= 1'b0;
        else       shadowBit <= sload;
      end

      assign mismatch = dummyQ ^ shadowBit;
    end
  endgenerate

  // R2: synchronous clear empties the sink.
  assert_clear_path_R2: assert property (@(posedge appClk) disable iff (!clrN)
    (strb.pickZero && strb.advance) |=> (sinkQ == ZERO_WORD));

  // R3: synchronous load takes the data word.
  assert_load_path_R3: assert property (@(posedge appClk) disable iff (!clrN)
    (strb.pickSdata && strb.advance) |=> (sinkQ == $past(sdata)));

  // R4: no enable, no change.
  assert_hold_R4: assert property (@(posedge appClk) disable iff (!clrN)
    !strb.advance |=> $stable(sinkQ));

endmodule

// File: rtl/slack_sensor.sv
module slack_sensor
  import slack_pkg::*;
#(
  parameter int       WIDTH       = 8,
  parameter variant_e VARIANT     = VAR_GATED,
  parameter bit       WATCH_SDATA = 1'b0
) (
  input  logic             appClk,
  input  logic             shadowClk,
  input  logic             discClk,
  input  logic             clrN,
  input  logic [WIDTH-1:0] lutOut,
  input  logic [WIDTH-1:0] sdata,
  input  logic             sload,
  input  logic             sclr,
  input  logic             clkEn,
  input  logic             discClear,
  output logic [WIDTH-1:0] sinkQ,
  output logic             timingErr
);

  strobes_t strb;
  logic     mismatch;

  slack_control #(
    .VARIANT    (VARIANT),
    .WATCH_SDATA(WATCH_SDATA)
  ) u_ctrl (
    .appClk   (appClk),
    .discClk  (discClk),
    .clrN     (clrN),
    .sload    (sload),
    .sclr     (sclr),
    .clkEn    (clkEn),
    .discClear(discClear),
    .mismatch (mismatch),
    .strb     (strb),
    .errFlag  (timingErr)
  );

  slack_datapath #(
    .WIDTH  (WIDTH),
    .VARIANT(VARIANT)
  ) u_dp (
    .appClk   (appClk),
    .shadowClk(shadowClk),
    .clrN     (clrN),
    .lutOut   (lutOut),
    .sdata    (sdata),
    .sload    (sload),
    .strb     (strb),
    .sinkQ    (sinkQ),
    .mismatch (mismatch)
  );

endmodule

// File: tb/sim_slack_sensor.sv
`timescale 1ns/100ps
module sim_slack_sensor;
  import slack_pkg::*;

  localparam int W = 8;

  logic appClk = 1'b0;
  logic shadowClk = 1'b0;
  logic discClk = 1'b0;
  logic clrN = 1'b0;
  logic [W-1:0] lutOut = '0;
  logic [W-1:0] sdata = '0;
  logic sload = 1'b0;
  logic sclr = 1'b0;
  logic clkEn = 1'b0;
  logic discClear = 1'b0;

  logic [W-1:0] sinkQ0, sinkQ1, sinkQ2;
  logic err0, err1, err2;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // 125 MHz clocks: shadow 2 ns behind, discrepancy 5 ns behind.
  always #4 appClk = ~appClk;
  initial begin #2; forever #4 shadowClk = ~shadowClk; end
  initial begin #5; forever #4 discClk = ~discClk; end

  // u0: gated on the LUT path
  slack_sensor #(.WIDTH(W), .VARIANT(VAR_GATED), .WATCH_SDATA(1'b0)) u0 (
    .appClk(appClk), .shadowClk(shadowClk), .discClk(discClk), .clrN(clrN),
    .lutOut(lutOut), .sdata(sdata), .sload(sload), .sclr(sclr), .clkEn(clkEn),
    .discClear(discClear), .sinkQ(sinkQ0), .timingErr(err0));
  // u1: dummy reference on the load select
  slack_sensor #(.WIDTH(W), .VARIANT(VAR_DUMMY), .WATCH_SDATA(1'b0)) u1 (
    .appClk(appClk), .shadowClk(shadowClk), .discClk(discClk), .clrN(clrN),
    .lutOut(lutOut), .sdata(sdata), .sload(sload), .sclr(sclr), .clkEn(clkEn),
    .discClear(discClear), .sinkQ(sinkQ1), .timingErr(err1));
  // u2: gated on the synchronous-data path
  slack_sensor #(.WIDTH(W), .VARIANT(VAR_GATED), .WATCH_SDATA(1'b1)) u2 (
    .appClk(appClk), .shadowClk(shadowClk), .discClk(discClk), .clrN(clrN),
    .lutOut(lutOut), .sdata(sdata), .sload(sload), .sclr(sclr), .clkEn(clkEn),
    .discClear(discClear), .sinkQ(sinkQ2), .timingErr(err2));

  task automatic checkVal(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkFlags(input string req, input logic e0, input logic e1, input logic e2);
    checkVal({req, " u0"}, {31'd0, err0}, {31'd0, e0});
    checkVal({req, " u1"}, {31'd0, err1}, {31'd0, e1});
    checkVal({req, " u2"}, {31'd0, err2}, {31'd0, e2});
  endtask

  // Change inputs after the shadow edge, well ahead of the next app edge.
  task automatic safeDrive(input logic [W-1:0] l, input logic [W-1:0] d,
                           input logic ld, input logic sc, input logic en);
    @(posedge appClk); #3;
    lutOut = l; sdata = d; sload = ld; sclr = sc; clkEn = en;
  endtask

  // Change inputs between the app edge and the shadow edge.
  task automatic lateDrive(input logic [W-1:0] l, input logic [W-1:0] d,
                           input logic ld, input logic sc, input logic en);
    @(posedge appClk); #1;
    lutOut = l; sdata = d; sload = ld; sclr = sc; clkEn = en;
  endtask

  task automatic sampleNext();
    @(posedge appClk); #7;
  endtask

  task automatic clearAll();
    @(posedge appClk); #3; discClear = 1'b1;
    @(posedge appClk); #3; discClear = 1'b0;
    sampleNext();
  endtask

  task automatic t_reset();
    #3;
    checkVal("R1 sinkQ in reset", {24'd0, sinkQ0}, 32'd0);
    checkFlags("R1 flags in reset", 1'b0, 1'b0, 1'b0);
    @(posedge appClk); #3; clrN = 1'b1;
  endtask

  task automatic t_paths();
    safeDrive(8'hA5, 8'h3C, 1'b0, 1'b0, 1'b1); sampleNext();
    checkVal("R2 lut path", {24'd0, sinkQ0}, 32'hA5);
    checkFlags("R6 safe lut", 1'b0, 1'b0, 1'b0);
    safeDrive(8'hA5, 8'h3C, 1'b1, 1'b0, 1'b1); sampleNext();
    checkVal("R3 load path", {24'd0, sinkQ0}, 32'h3C);
    checkVal("R3 load path u1", {24'd0, sinkQ1}, 32'h3C);
    checkFlags("R6 safe load", 1'b0, 1'b0, 1'b0);
    safeDrive(8'hA5, 8'h3C, 1'b1, 1'b1, 1'b1); sampleNext();
    checkVal("R2 clear over load", {24'd0, sinkQ0}, 32'h00);
    checkFlags("R6 safe clear", 1'b0, 1'b0, 1'b0);
    safeDrive(8'h77, 8'h3C, 1'b0, 1'b0, 1'b0); sampleNext();
    checkVal("R4 hold", {24'd0, sinkQ2}, 32'h00);
    lateDrive(8'h18, 8'h3C, 1'b0, 1'b0, 1'b0); #6;
    checkFlags("R4 late change while disabled", 1'b0, 1'b0, 1'b0);
    sampleNext();
    checkVal("R4 still held", {24'd0, sinkQ0}, 32'h00);
  endtask

  task automatic t_lateLut();
    safeDrive(8'h11, 8'h22, 1'b0, 1'b0, 1'b1); sampleNext();
    checkVal("R2 base lut", {24'd0, sinkQ0}, 32'h11);
    lateDrive(8'h99, 8'h22, 1'b0, 1'b0, 1'b1); #6;
    checkFlags("R5 R9 R10 late lut", 1'b1, 1'b0, 1'b0);
    sampleNext();
    checkFlags("R7 sticky after catch-up", 1'b1, 1'b0, 1'b0);
    clearAll();
    checkFlags("R7 cleared", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_lateSdata();
    safeDrive(8'h11, 8'h22, 1'b1, 1'b0, 1'b1); sampleNext();
    checkVal("R3 base load", {24'd0, sinkQ0}, 32'h22);
    lateDrive(8'h11, 8'h66, 1'b1, 1'b0, 1'b1); #6;
    checkFlags("R8 R9 late sdata", 1'b0, 1'b0, 1'b1);
    clearAll();
    checkFlags("R7 cleared after sdata", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_lateLoad();
    safeDrive(8'h11, 8'h66, 1'b0, 1'b0, 1'b1); sampleNext();
    checkVal("R2 base before load", {24'd0, sinkQ0}, 32'h11);
    lateDrive(8'h11, 8'h66, 1'b1, 1'b0, 1'b1); #6;
    checkFlags("R10 R11 late load", 1'b1, 1'b1, 1'b0);
    clearAll();
    checkFlags("R7 cleared after load", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_lateClear();
    safeDrive(8'h11, 8'h66, 1'b0, 1'b0, 1'b1); sampleNext();
    checkFlags("R6 safe load drop", 1'b0, 1'b0, 1'b0);
    lateDrive(8'h11, 8'h66, 1'b0, 1'b1, 1'b1); #6;
    checkFlags("R11 R10 late sclr", 1'b1, 1'b0, 1'b0);
    sampleNext();
    checkVal("R2 clear reached sink", {24'd0, sinkQ0}, 32'h00);
    clearAll();
    checkFlags("R7 cleared after sclr", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_clearPriority();
    safeDrive(8'h11, 8'h66, 1'b0, 1'b0, 1'b1); sampleNext();
    @(posedge appClk); #1; lutOut = 8'h5A; discClear = 1'b1; #6;
    checkFlags("R7 clear wins over hit", 1'b0, 1'b0, 1'b0);
    #1; discClear = 1'b0;
  endtask

  task automatic t_midReset();
    safeDrive(8'h11, 8'h66, 1'b0, 1'b0, 1'b1); sampleNext();
    lateDrive(8'hC3, 8'h66, 1'b0, 1'b0, 1'b1); #6;
    checkFlags("R5 before async clear", 1'b1, 1'b0, 1'b0);
    @(posedge appClk); #3; clrN = 1'b0; #1;
    checkVal("R1 async sink clear", {24'd0, sinkQ0}, 32'd0);
    checkFlags("R1 async flag clear", 1'b0, 1'b0, 1'b0);
    #2; clrN = 1'b1;
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    t_reset();
    t_paths();
    t_lateLut();
    t_lateSdata();
    t_lateLoad();
    t_lateClear();
    t_clearPriority();
    t_midReset();
    done = 1'b1;
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge appClk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finishRun();
    end
  end

endmodule